// File: doc/BRIEF.md
# Accumulator Machine Instruction Sequencer

This block is the control and datapath of a small accumulator machine. Code and data sit in one synchronous single-port memory. Every memory access goes through an address holding register and a data holding register. Each instruction starts with four register-transfer steps that fetch it. The instruction word is then split into an opcode and an operand. Next the block runs the execute steps for that opcode, and at the end it reaches a boundary state where interrupts are polled.

Interrupt requests arrive on a request vector. A companion priority vector marks each source as urgent or not. Only urgent sources are ever taken. When the interrupt enable is set, the block saves its programmer-visible registers on a descending memory stack, disables further interrupts and jumps to a computed per-source handler address. A return instruction unstacks the registers in the reverse order and enables interrupts again.

Top module: `acc_cpu`

## Requirements
- R1: While reset is low the memory address output is 0, write enable is low and `halted` is low. After reset the first instruction is fetched from address 0, the stack pointer starts at the highest address, the accumulator and index are 0, and interrupts are enabled.
- R2: A fetch takes four steps in order: the address register takes the PC, the PC increments by one, the data register takes the memory word, and the instruction register takes the data register.
- R3: Bits [15:12] of an instruction word are the opcode and bits [11:0] are the operand. The codes are: 0 load immediate, 1 load direct, 2 load indexed, 3 store, 4 add, 5 subtract, 6 compare, 7 jump, 8 jump if equal, 9 jump if not equal, A return from interrupt, B load index immediate, F halt. Codes C, D and E do nothing.
- R4: Load immediate zero-extends the operand into ACC. Load direct and load indexed copy a memory word into ACC. The indexed address is operand plus IX modulo 4096. Store writes ACC to the operand address. Load index immediate sets IX.
- R5: Add and subtract put ACC plus or minus the memory word into ACC. Both set status bit 1 when the signed result overflows and clear it otherwise.
- R6: Compare sets status bit 0 when ACC equals the memory word and clears it otherwise. Jump always loads the PC with the operand. Jump-if-equal and jump-if-not-equal do so only when bit 0 is set or clear, respectively.
- R7: After halt, `halted` stays high and no memory write occurs.
- R8: Requests are only examined after an instruction has completed. A pending source whose priority bit is 0 is never serviced.
- R9: When several urgent sources are pending, the lowest-numbered one is served. Its handler starts at VEC_BASE + source * VEC_STEP.
- R10: Entry pushes, in this order, the return PC, ACC, IX and the status word {14'b0, bit1, bit0}. They go to the addresses SP, SP-1, SP-2 and SP-3. Entry then clears the interrupt enable, so a handler is never interrupted.
- R11: Return from interrupt pops status, IX, ACC and PC from SP+1 upward, restores them and re-enables interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 12 | Memory address (from the address register) |
| mem_wdata | output | 16 | Memory write data (from the data register) |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| mem_we | output | 1 | Memory write enable |
| irq_req | input | 4 | Interrupt request per source |
| irq_hi | input | 4 | Priority per source, 1 means urgent |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
Separate programs cover arithmetic with positive and negative results, and indexed loads with and without wrap of the address. A branch chain tests every conditional outcome, so a jump that ignores its flag would write to a cell that must stay empty. An interrupt scenario raises two urgent sources and one non-urgent source together, then raises a third source in the middle of the program. The order of handler acknowledgements shows the priority selection, and an untouched guard cell below the stack shows that handlers did not nest. The stacked words and the values restored after return show the push order, the pop order and the saved overflow flag.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int OPW = 4;

  localparam logic [OPW-1:0] OP_LDM = 4'h0;
  localparam logic [OPW-1:0] OP_LDD = 4'h1;
  localparam logic [OPW-1:0] OP_LDX = 4'h2;
  localparam logic [OPW-1:0] OP_STO = 4'h3;
  localparam logic [OPW-1:0] OP_ADD = 4'h4;
  localparam logic [OPW-1:0] OP_SUB = 4'h5;
  localparam logic [OPW-1:0] OP_CMP = 4'h6;
  localparam logic [OPW-1:0] OP_JMP = 4'h7;
  localparam logic [OPW-1:0] OP_JPE = 4'h8;
  localparam logic [OPW-1:0] OP_JPN = 4'h9;
  localparam logic [OPW-1:0] OP_RTI = 4'hA;
  localparam logic [OPW-1:0] OP_LIX = 4'hB;
  localparam logic [OPW-1:0] OP_HLT = 4'hF;

  typedef enum logic [4:0] {
    S_F1, S_F2, S_F3, S_F4, S_DEC,
    S_RD1, S_RD2, S_EXE, S_ST, S_CHK,
    S_PSA, S_PSW, S_POA, S_POW, S_POR, S_POL,
    S_HALT
  } seq_state_t;
endpackage

// File: rtl/acc_cpu_rstsync.sv
module acc_cpu_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q = sync_q[1];
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  output logic [DW-1:0] res,
  output logic          ovf
);
  logic [DW-1:0] b_eff;

  always_comb begin
    b_eff = sub ? ~b : b;
    res   = a + b_eff + {{(DW-1){1'b0}}, sub};
    ovf   = (a[DW-1] == b_eff[DW-1]) && (res[DW-1] != a[DW-1]);
  end
endmodule

// File: rtl/acc_cpu_irq.sv
module acc_cpu_irq #(
  parameter int NSRC     = 4,
  parameter int AW       = 12,
  parameter int VEC_BASE = 2048,
  parameter int VEC_STEP = 16
) (
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] hi,
  input  logic            enable,
  output logic            take,
  output logic [AW-1:0]   vec
);
  logic [NSRC-1:0] urgent;

  always_comb begin
    urgent = req & hi;
    take   = enable && (|urgent);
    vec    = AW'(VEC_BASE);
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (urgent[i]) vec = AW'(VEC_BASE + i * VEC_STEP);
    end
  end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DW       = 16,
  parameter int AW       = 12,
  parameter int NSRC     = 4,
  parameter int VEC_BASE = 2048,
  parameter int VEC_STEP = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic            mem_we,
  input  logic [NSRC-1:0] irq_req,
  input  logic [NSRC-1:0] irq_hi,
  output logic            halted
);
  localparam int ZW = DW - AW;

  seq_state_t    st, st_n;
  logic [AW-1:0] pc, pc_n, mar, mar_n, sp, sp_n, vec_q, vec_n;
  logic [DW-1:0] mdr, mdr_n, cir, cir_n, acc, acc_n, ix, ix_n;
  logic          f_eq, f_eq_n, f_v, f_v_n, irq_en, irq_en_n;
  logic [1:0]    cnt, cnt_n;
  logic          rst_q;

  logic [OPW-1:0] opc;
  logic [AW-1:0]  opnd;
  logic [DW-1:0]  alu_res;
  logic           alu_ovf, irq_take;
  logic [AW-1:0]  irq_vec;

  assign opc  = cir[DW-1 -: OPW];
  assign opnd = cir[AW-1:0];

  acc_cpu_rstsync u_rst (.clk(clk), .rst_n(rst_n), .rst_q(rst_q));

  acc_cpu_alu #(.DW(DW)) u_alu (
    .a(acc), .b(mdr), .sub(opc == OP_SUB), .res(alu_res), .ovf(alu_ovf)
  );

  acc_cpu_irq #(.NSRC(NSRC), .AW(AW), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_irq (
    .req(irq_req), .hi(irq_hi), .enable(irq_en), .take(irq_take), .vec(irq_vec)
  );

  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign mem_we    = (st == S_ST) || (st == S_PSW);
  assign halted    = (st == S_HALT);

  always_comb begin
    st_n = st; pc_n = pc; mar_n = mar; sp_n = sp; vec_n = vec_q;
    mdr_n = mdr; cir_n = cir; acc_n = acc; ix_n = ix;
    f_eq_n = f_eq; f_v_n = f_v; irq_en_n = irq_en; cnt_n = cnt;
    case (st)
      S_F1: begin mar_n = pc; st_n = S_F2; end
      S_F2: begin pc_n = pc + 1'b1; st_n = S_F3; end
      S_F3: begin mdr_n = mem_rdata; st_n = S_F4; end
      S_F4: begin cir_n = mdr; st_n = S_DEC; end
      S_DEC: begin
        st_n = S_CHK;
        case (opc)
          OP_LDM: acc_n = {{ZW{1'b0}}, opnd};
          OP_LIX: ix_n  = {{ZW{1'b0}}, opnd};
          OP_LDD, OP_ADD, OP_SUB, OP_CMP: begin mar_n = opnd; st_n = S_RD1; end
          OP_LDX: begin mar_n = opnd + ix[AW-1:0]; st_n = S_RD1; end
          OP_STO: begin mar_n = opnd; mdr_n = acc; st_n = S_ST; end
          OP_JMP: pc_n = opnd;
          OP_JPE: if (f_eq)  pc_n = opnd;
          OP_JPN: if (!f_eq) pc_n = opnd;
          OP_RTI: begin cnt_n = 2'd0; st_n = S_POA; end
          OP_HLT: st_n = S_HALT;
          default: ;
        endcase
      end
      S_RD1: st_n = S_RD2;
      S_RD2: begin mdr_n = mem_rdata; st_n = S_EXE; end
      S_EXE: begin
        st_n = S_CHK;
        case (opc)
          OP_ADD, OP_SUB: begin acc_n = alu_res; f_v_n = alu_ovf; end
          OP_CMP:         f_eq_n = (acc == mdr);
          default:        acc_n = mdr;
        endcase
      end
      S_ST: st_n = S_CHK;
      S_CHK: begin
        if (irq_take) begin vec_n = irq_vec; cnt_n = 2'd0; st_n = S_PSA; end
        else st_n = S_F1;
      end
      S_PSA: begin
        mar_n = sp; sp_n = sp - 1'b1; st_n = S_PSW;
        case (cnt)
          2'd0:    mdr_n = {{ZW{1'b0}}, pc};
          2'd1:    mdr_n = acc;
          2'd2:    mdr_n = ix;
          default: mdr_n = {{(DW-2){1'b0}}, f_v, f_eq};
        endcase
      end
      S_PSW: begin
        cnt_n = cnt + 1'b1;
        if (cnt == 2'd3) begin pc_n = vec_q; irq_en_n = 1'b0; st_n = S_F1; end
        else st_n = S_PSA;
      end
      S_POA: begin sp_n = sp + 1'b1; mar_n = sp + 1'b1; st_n = S_POW; end
      S_POW: st_n = S_POR;
      S_POR: begin mdr_n = mem_rdata; st_n = S_POL; end
      S_POL: begin
        cnt_n = cnt + 1'b1;
        case (cnt)
          2'd0:    begin f_v_n = mdr[1]; f_eq_n = mdr[0]; end
          2'd1:    ix_n  = mdr;
          2'd2:    acc_n = mdr;
          default: pc_n  = mdr[AW-1:0];
        endcase
        if (cnt == 2'd3) begin irq_en_n = 1'b1; st_n = S_CHK; end
        else st_n = S_POA;
      end
      default: st_n = S_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_F1; pc <= '0; mar <= '0; sp <= '1; vec_q <= '0;
      mdr <= '0; cir <= '0; acc <= '0; ix <= '0;
      f_eq <= 1'b0; f_v <= 1'b0; irq_en <= 1'b1; cnt <= 2'd0;
    end else if (rst_q) begin
      st <= st_n; pc <= pc_n; mar <= mar_n; sp <= sp_n; vec_q <= vec_n;
      mdr <= mdr_n; cir <= cir_n; acc <= acc_n; ix <= ix_n;
      f_eq <= f_eq_n; f_v <= f_v_n; irq_en <= irq_en_n; cnt <= cnt_n;
    end
  end

  assert_fetch_inc_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (st == S_F2) |=> (pc == AW'($past(pc) + 1'b1)));
  assert_cir_load_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (st == S_F4) |=> (cir == $past(mdr)));
  assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_q)
    halted |=> (halted && !mem_we));
  assert_sp_only_stack_R10: assert property (@(posedge clk) disable iff (!rst_q)
    (st != S_PSA && st != S_POA) |=> $stable(sp));
  assert_no_nest_R10: assert property (@(posedge clk) disable iff (!rst_q)
    (st == S_CHK && !irq_en) |=> (st == S_F1));
  assert_boundary_poll_R8: assert property (@(posedge clk) disable iff (!rst_q)
    (st == S_PSA && cnt == 2'd0) |-> ($past(st) == S_CHK));
  assert_rti_enable_R11: assert property (@(posedge clk) disable iff (!rst_q)
    (st == S_POL && cnt == 2'd3) |=> irq_en);
endmodule

// File: tb/acc_cpu_bench.sv
module acc_cpu_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        mem_we;
  logic [3:0]  irq_req;
  logic [3:0]  irq_hi;
  logic        halted;

  logic [15:0] mem [0:4095];
  int          total = 0;
  int          bad = 0;
  int          wr_cnt = 0;
  int          ack_n = 0;
  logic [11:0] ack_log [0:7];

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_cpu u_acc_cpu (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .irq_req(irq_req), .irq_hi(irq_hi),
    .halted(halted)
  );

  always @(posedge clk) begin
    mem_rdata <= mem[mem_addr];
    if (mem_we) begin
      mem[mem_addr] = mem_wdata;
      wr_cnt = wr_cnt + 1;
      if (mem_addr == 12'h0F0 || mem_addr == 12'h0F1 || mem_addr == 12'h0F2 || mem_addr == 12'h0F3) begin
        if (ack_n < 8) ack_log[ack_n] = mem_addr;
        ack_n = ack_n + 1;
      end
      if (mem_addr == 12'h0F0) irq_req[1] = 1'b0;
      if (mem_addr == 12'h0F2) irq_req[2] = 1'b0;
      if (mem_addr == 12'h0F1) irq_req[3] = 1'b0;
      if (mem_addr == 12'd210) irq_req[3] = 1'b1;
    end
  end

  function automatic logic [15:0] enc(input int op, input int arg);
    logic [3:0]  o;
    logic [11:0] a;
    o = op[3:0];
    a = arg[11:0];
    return {o, a};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_mem(input int addr, input int exp, input string tag);
    chk(mem[addr] == exp[15:0], tag, int'(mem[addr]), exp);
  endtask

  task automatic start_reset(input logic [3:0] req, input logic [3:0] hi);
    rst_n = 1'b0;
    irq_req = req;
    irq_hi = hi;
    ack_n = 0;
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
  endtask

  task automatic release_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_halt(input string tag);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (halted) break;
    end
    chk(halted == 1'b1, tag, int'(halted), 1);
  endtask

  task automatic t_reset();
    start_reset(4'h0, 4'h0);
    repeat (2) @(negedge clk);
    chk(mem_addr == 12'd0, "R1 addr in reset", int'(mem_addr), 0);
    chk(mem_we == 1'b0, "R1 we in reset", int'(mem_we), 0);
    chk(halted == 1'b0, "R1 halted in reset", int'(halted), 0);
  endtask

  task automatic t_arith();
    int w0;
    start_reset(4'h0, 4'h0);
    mem[0] = enc(0, 5);
    mem[1] = enc(4, 100);
    mem[2] = enc(3, 200);
    mem[3] = enc(5, 101);
    mem[4] = enc(3, 201);
    mem[5] = enc(15, 0);
    mem[100] = 16'd7;
    mem[101] = 16'd20;
    release_reset();
    wait_halt("R7 arith halts");
    chk_mem(200, 16'd12, "R5 add result");
    chk_mem(201, 16'hFFF8, "R5 sub negative");
    w0 = wr_cnt;
    repeat (30) @(negedge clk);
    chk(wr_cnt == w0, "R7 no writes after halt", wr_cnt, w0);
    chk(halted == 1'b1, "R7 halted holds", int'(halted), 1);
  endtask

  task automatic t_index();
    start_reset(4'h0, 4'h0);
    mem[0] = enc(11, 3);
    mem[1] = enc(2, 300);
    mem[2] = enc(3, 202);
    mem[3] = enc(11, 12'hFFF);
    mem[4] = enc(2, 6);
    mem[5] = enc(3, 207);
    mem[6] = enc(15, 0);
    mem[303] = 16'hABCD;
    release_reset();
    wait_halt("R4 index halts");
    chk_mem(202, 16'hABCD, "R4 indexed load");
    chk_mem(207, 16'h30CF, "R4 indexed address wraps");
  endtask

  task automatic t_branch();
    start_reset(4'h0, 4'h0);
    mem[0]  = enc(0, 9);
    mem[1]  = enc(6, 110);
    mem[2]  = enc(8, 5);
    mem[3]  = enc(0, 1);
    mem[4]  = enc(3, 203);
    mem[5]  = enc(6, 111);
    mem[6]  = enc(9, 9);
    mem[7]  = enc(0, 2);
    mem[8]  = enc(3, 204);
    mem[9]  = enc(3, 205);
    mem[10] = enc(7, 12);
    mem[11] = enc(3, 206);
    mem[12] = enc(13, 0);
    mem[13] = enc(15, 0);
    mem[110] = 16'd9;
    mem[111] = 16'd4;
    release_reset();
    wait_halt("R3 branch halts");
    chk_mem(203, 16'd0, "R6 equal branch taken");
    chk_mem(204, 16'd0, "R6 not-equal branch taken");
    chk_mem(205, 16'd9, "R6 fall-through store");
    chk_mem(206, 16'd0, "R6 unconditional jump");
  endtask

  task automatic t_irq();
    start_reset(4'b0111, 4'b1110);
    mem[0] = enc(1, 102);
    mem[1] = enc(4, 103);
    mem[2] = enc(11, 5);
    mem[3] = enc(3, 210);
    mem[4] = enc(3, 211);
    mem[5] = enc(2, 300);
    mem[6] = enc(3, 212);
    mem[7] = enc(15, 0);
    mem[102] = 16'h7FFF;
    mem[103] = 16'h0001;
    mem[305] = 16'h1234;
    mem[12'h800] = enc(3, 12'h0F3);
    mem[12'h801] = enc(10, 0);
    mem[12'h810] = enc(3, 12'h0F0);
    mem[12'h811] = enc(10, 0);
    mem[12'h820] = enc(3, 12'h0F2);
    mem[12'h821] = enc(10, 0);
    mem[12'h830] = enc(0, 12'h055);
    mem[12'h831] = enc(3, 12'h0F1);
    mem[12'h832] = enc(11, 7);
    mem[12'h833] = enc(10, 0);
    mem[4091] = 16'hDEAD;
    release_reset();
    wait_halt("R8 irq program halts");
    chk(ack_n == 3, "R8 handler count", ack_n, 3);
    chk(ack_log[0] == 12'h0F0, "R9 lowest urgent first", int'(ack_log[0]), 12'h0F0);
    chk(ack_log[1] == 12'h0F2, "R9 next urgent", int'(ack_log[1]), 12'h0F2);
    chk(ack_log[2] == 12'h0F1, "R9 late source", int'(ack_log[2]), 12'h0F1);
    chk_mem(12'h0F3, 16'd0, "R8 non-urgent ignored");
    chk_mem(12'h0F0, 16'h7FFF, "R8 served after instruction");
    chk_mem(210, 16'h8000, "R5 overflow sum");
    chk_mem(4095, 16'd4, "R10 pushed PC");
    chk_mem(4094, 16'h8000, "R10 pushed ACC");
    chk_mem(4093, 16'd5, "R10 pushed IX");
    chk_mem(4092, 16'd2, "R10 pushed status with overflow");
    chk_mem(4091, 16'hDEAD, "R10 no nesting");
    chk_mem(12'h0F1, 16'h0055, "R10 handler runs");
    chk_mem(211, 16'h8000, "R11 ACC restored");
    chk_mem(212, 16'h1234, "R11 IX restored");
  endtask

  initial begin
    fork
      begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none
    t_reset();
    t_arith();
    t_index();
    t_branch();
    t_irq();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule